// File: doc/BRIEF.md
# Inbound MSI Vector Capture Unit

This block sits beside the inbound write path of a PCIe root port and turns message-signalled interrupts into pending bits. Every inbound memory write arrives as a valid/ready transfer. A write whose address equals the programmed target address is taken as an MSI. Its data value names the vector, and the block latches that vector in a 32-bit pending register. Any other write goes out unchanged on a downstream valid/ready port.

Software sees the unit through a small register port. One register holds the target address, which can be written and read back. The other shows the pending vectors, and writing ones to it clears them. The OR of all pending bits drives a summary flag, which feeds the MSI input (bit 28) of the local interrupt aggregator. An MSI whose data is out of range latches nothing and raises a one-cycle error pulse instead.

Back-pressure works as follows. A write that hits the target is always taken in the cycle it is offered, so `in_ready` is high for it. A write that misses the target is passed through combinationally: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. A missed write is consumed only in a cycle where both valid and ready are high.

Top module: `msi_capture`

## Requirements
- R1: After reset the pending register reads 0, the target register reads the `TARGET_RST` parameter (default 0xFFFF_F000), and `msi_pending` and `msi_err` are low.
- R2: An accepted inbound write to the target address with data d in 0..31 sets pending bit d. The bit is visible at register offset 0x194 from the cycle after the transfer.
- R3: Pending bits latch independently. A second MSI to a different vector adds its bit and leaves the others as they were.
- R4: A register write to offset 0x194 clears each pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: A register write of 0xFFFF_FFFF to offset 0x194 clears every pending vector.
- R6: `msi_pending` is high exactly while at least one pending bit is set. It rises only in the cycle after an accepted MSI.
- R7: An MSI (target address hit) with data of 32 or more changes no pending bit. It makes `msi_err` high for exactly the one cycle after the transfer.
- R8: When an MSI sets vector d in the same cycle that software clears bit d, bit d ends up set.
- R9: An inbound write to any other address is forwarded with its address and data unchanged on `out_addr`/`out_data`, and it sets no pending bit.
- R10: A target-hit write has `in_ready` high whatever the level of `out_ready`, and it never shows `out_valid`. A non-hit write has `in_ready` equal to `out_ready`.
- R11: Writing the target register at offset 0x190 changes the address that is matched. Later MSIs are recognised only at the new address.
- R12: A register read of any offset other than 0x190 and 0x194 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound write offered |
| in_ready | output | 1 | Inbound write accepted |
| in_addr | input | 32 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| out_valid | output | 1 | Forwarded write valid |
| out_ready | input | 1 | Downstream ready |
| out_addr | output | 32 | Forwarded write address |
| out_data | output | 32 | Forwarded write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| msi_pending | output | 1 | Summary: any vector pending |
| msi_err | output | 1 | One-cycle pulse on out-of-range MSI data |

## Verification
The capture path is driven with MSIs to the lowest vector, the highest vector, middle vectors and an out-of-range value, each mixed with partial and full clears. This separates a wrong bit index from wrong accumulation and from wrong clearing. A set and a clear to the same bit in the same cycle shows which of the two wins. Off-target writes are sent with the downstream port stalled and then released, which separates forwarding from capture and checks the ready rules. The target address is then moved to a new value: an MSI at the old address is forwarded and one at the new address is captured.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_TARGET = 12'h190;
  localparam logic [REG_AW-1:0] OFS_PEND   = 12'h194;
endpackage

// File: rtl/msi_match.sv
module msi_match #(
  parameter int unsigned VEC_N = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] target,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic [VEC_N-1:0] set_vec,
  output logic          bad_vec
);
  logic hit;
  assign hit       = in_valid && (in_addr == target);
  // a hit is always consumed; a miss waits for the downstream side
  assign in_ready  = hit ? 1'b1 : out_ready;
  assign out_valid = in_valid && !hit;
  assign out_addr  = in_addr;
  assign out_data  = in_data;
  assign bad_vec   = hit && (in_data >= DW'(VEC_N));

  for (genvar i = 0; i < VEC_N; i++) begin : g_dec
    assign set_vec[i] = hit && (in_data == DW'(i));
  end
endmodule

// File: rtl/msi_pending_bank.sv
module msi_pending_bank #(
  parameter int unsigned VEC_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_N-1:0] set_vec,
  input  logic [VEC_N-1:0] clr_vec,
  output logic [VEC_N-1:0] pend,
  output logic             any_pend
);
  for (genvar i = 0; i < VEC_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (set_vec[i]) pend[i] <= 1'b1;   // new message beats clear
      else if (clr_vec[i]) pend[i] <= 1'b0;
    end
  end
  assign any_pend = |pend;
endmodule

// File: rtl/msi_regfile.sv
module msi_regfile
  import msi_cap_pkg::*;
#(
  parameter int unsigned     VEC_N      = 32,
  parameter int unsigned     AW         = 32,
  parameter logic [AW-1:0]   TARGET_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [VEC_N-1:0]  pend,
  output logic [AW-1:0]     target,
  output logic [VEC_N-1:0]  clr_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n)                               target <= TARGET_RST;
    else if (reg_we && reg_addr == OFS_TARGET) target <= AW'(reg_wdata);
  end

  assign clr_vec = (reg_we && reg_addr == OFS_PEND) ? VEC_N'(reg_wdata) : '0;

  always_comb begin
    unique case (reg_addr)
      OFS_TARGET: reg_rdata = 32'(target);
      OFS_PEND:   reg_rdata = 32'(pend);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_capture.sv
module msi_capture
  import msi_cap_pkg::*;
#(
  parameter int unsigned   VEC_N      = 32,
  parameter int unsigned   AW         = 32,
  parameter int unsigned   DW         = 32,
  parameter logic [AW-1:0] TARGET_RST = 32'hFFFF_F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [DW-1:0]     out_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msi_pending,
  output logic              msi_err
);
  logic [AW-1:0]    target_q;
  logic [VEC_N-1:0] pend_q;
  logic [VEC_N-1:0] set_vec;
  logic [VEC_N-1:0] clr_vec;
  logic             bad_vec;
  logic             err_q;

  msi_match #(.VEC_N(VEC_N), .AW(AW), .DW(DW)) u_match (
    .in_valid (in_valid),  .in_ready (in_ready),
    .in_addr  (in_addr),   .in_data  (in_data),
    .target   (target_q),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr (out_addr),  .out_data (out_data),
    .set_vec  (set_vec),   .bad_vec  (bad_vec)
  );

  msi_pending_bank #(.VEC_N(VEC_N)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec),
    .pend(pend_q), .any_pend(msi_pending)
  );

  msi_regfile #(.VEC_N(VEC_N), .AW(AW), .TARGET_RST(TARGET_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pend(pend_q), .target(target_q), .clr_vec(clr_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad_vec;
  end
  assign msi_err = err_q;
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk
  import msi_cap_pkg::*;
#(
  parameter int unsigned VEC_N = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [AW-1:0]     in_addr,
  input logic [DW-1:0]     in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [VEC_N-1:0]  pend,
  input logic [AW-1:0]     target,
  input logic              summary,
  input logic              err
);
  logic hit;
  assign hit = in_valid && in_ready && (in_addr == target);

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && in_data < DW'(VEC_N)) |=> pend[$past(in_data[$clog2(VEC_N)-1:0])]); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_PEND && !hit) |=> ((pend & $past(VEC_N'(reg_wdata))) == '0)); // R4
  AST_SUMMARY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(summary) |-> $past(hit)); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(hit && in_data >= DW'(VEC_N))); // R7
  AST_BAD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && in_data >= DW'(VEC_N) && !reg_we) |=> $stable(pend)); // R7
  AST_MISS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ((pend & ~$past(pend)) == '0)); // R9
  AST_FWD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_addr != target && in_ready == out_ready)); // R10
endmodule

bind msi_capture msi_capture_chk #(.VEC_N(VEC_N), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .pend(pend_q), .target(target_q), .summary(msi_pending), .err(msi_err)
);

// File: tb/msi_capture_bench.sv
module msi_capture_bench;
  localparam logic [31:0] TGT  = 32'hFFFF_F000;
  localparam logic [31:0] TGT2 = 32'h1234_5000;
  localparam int NROW = 8;
  localparam logic [31:0] T_DATA [NROW] = '{32'd0, 32'd31, 32'd5, 32'd40,
                                            32'd7, 32'd31, 32'd16, 32'd3};
  localparam logic [31:0] T_CLR  [NROW] = '{32'h0, 32'h0, 32'h0, 32'h0,
                                            32'h1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0};
  localparam logic [31:0] T_EXP  [NROW] = '{32'h1, 32'h8000_0001, 32'h8000_0021,
                                            32'h8000_0021, 32'h8000_00A0, 32'hA0,
                                            32'h0, 32'h8};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] in_addr = '0, in_data = '0, out_addr, out_data;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msi_pending, msi_err;
  int checks = 0, failures = 0;
  logic last_err;
  logic [31:0] v;

  always #10 clk = ~clk;

  msi_capture u_msi_capture (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msi_pending(msi_pending), .msi_err(msi_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk); in_valid = 1'b0; last_err = msi_err;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(12'h194, v); check("R1 pending", v, 32'h0);
    rd(12'h190, v); check("R1 target", v, TGT);
    check("R1 summary/err", {30'b0, msi_pending, msi_err}, 32'h0);

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NROW; i++) begin
      send(TGT, T_DATA[i]);
      check(T_DATA[i] >= 32 ? "R7 err pulse" : "R2 no err", {31'b0, last_err},
            {31'b0, T_DATA[i] >= 32});
      if (T_CLR[i] != 0) wr(12'h194, T_CLR[i]);
      rd(12'h194, v);
      check(T_CLR[i] == 32'hFFFF_FFFF ? "R5 clear all" : "R3 R4 pending", v, T_EXP[i]);
      check("R6 summary", {31'b0, msi_pending}, {31'b0, T_EXP[i] != 0});
    end
    @(negedge clk); check("R7 err one cycle", {31'b0, msi_err}, 32'h0);

    // R8 simultaneous set and clear of bit 9
    send(TGT, 32'd9);
    @(negedge clk); in_valid = 1'b1; in_addr = TGT; in_data = 32'd9;
    reg_we = 1'b1; reg_addr = 12'h194; reg_wdata = 32'h200;
    @(negedge clk); in_valid = 1'b0; reg_we = 1'b0;
    rd(12'h194, v); check("R8 set wins", v, 32'h208);

    // R9 R10 pass-through under back-pressure
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'hABCD_0040; in_data = 32'd2;
    #1;
    check("R9 fwd valid", {31'b0, out_valid}, 32'h1);
    check("R10 stalled ready", {31'b0, in_ready}, 32'h0);
    check("R9 fwd addr", out_addr, 32'hABCD_0040);
    check("R9 fwd data", out_data, 32'd2);
    @(negedge clk); out_ready = 1'b1; #1;
    check("R10 ready follows", {31'b0, in_ready}, 32'h1);
    @(negedge clk); in_valid = 1'b0;
    rd(12'h194, v); check("R9 no set", v, 32'h208);
    // R10 hit accepted while stalled
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_addr = TGT; in_data = 32'd1; #1;
    check("R10 hit ready", {30'b0, in_ready, out_valid}, 32'h2);
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    rd(12'h194, v); check("R10 hit captured", v, 32'h20A);

    // R11 retarget
    wr(12'h194, 32'hFFFF_FFFF);
    wr(12'h190, TGT2);
    rd(12'h190, v); check("R11 target rb", v, TGT2);
    send(TGT, 32'd4);
    rd(12'h194, v); check("R11 old addr ignored", v, 32'h0);
    send(TGT2, 32'd4);
    rd(12'h194, v); check("R11 new addr hits", v, 32'h10);

    // R12 other offsets
    rd(12'h180, v); check("R12 other offset", v, 32'h0);
    rd(12'h198, v); check("R12 other offset", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule